// File: doc/BRIEF.md
# Idle-Timeout Display Blanker

This block sits between the display data path and the segment drivers of a scanned calculator display. It watches the key-event stream. When no key has been accepted for a set number of scan periods, it enters a low-power blank state. In that state every digit slot leaves the block dark, except the leftmost slot, which shows only the minus bar. The upstream display store is never written by this block, so the content that was on show returns unchanged when the block wakes.

Only some keys wake the block. Rows are picked by a per-row enable mask. Separately, a dedicated wake row wakes the block when its key is read on either of the two lowest columns. A strap input turns the feature off.

All three data interfaces are valid/ready. The display path is a combinational pass-through: `din_ready` follows `dout_ready` and `dout_valid` follows `din_valid`, so a stall downstream holds the digit upstream. Key events enter through a one-entry output register. `key_ready` is high whenever that register is empty or is being drained in the same cycle. While `fwd_valid` is high and `fwd_ready` is low, the forwarded event is held stable.

Top module: `tmo_blanker`

## Requirements
- R1: After reset the block is not blanked, holds no forwarded key (`fwd_valid`=0), and accepts keys (`key_ready`=1).
- R2: The block becomes blanked at the TIMEOUT_SCANS-th `scan_tick` after the last accepted key, and not at any earlier tick.
- R3: Every accepted key event restarts the idle count from zero. This includes keys that are dropped while blanked.
- R4: While blanked, a slot with digit index NUM_DIGITS-1 (leftmost) leaves with segments 8'h40. Segment bits are ordered bit0=a … bit6=g (minus), bit7=decimal point. Every other slot leaves with 8'h00.
- R5: While not blanked, `dout_seg` and `dout_digit` equal `din_seg` and `din_digit`. The earlier content therefore reappears untouched after a wake.
- R6: A key accepted while blanked, in a row r with `wake_rows[r]`=1 and on any column, ends the blank state at the next `scan_tick`. A key in a row with the mask bit clear does not end it.
- R7: A key on row DEDICATED_ROW (default index 10) with column 0 or 1 wakes the block regardless of the mask. The same row with column 2 does not wake it.
- R8: While `strap_off` is high the block is never blanked. Raising it during the blank state clears that state on the next clock edge.
- R9: A key accepted while not blanked is forwarded. A key accepted while blanked is forwarded only if it is a wake key and `pass_wake`=1. Otherwise it is dropped.
- R10: The forwarded key is held stable while `fwd_ready`=0, and `key_ready` is low while it is held. The display stream keeps `dout_valid`=`din_valid` and `din_ready`=`dout_ready`.
- R11: Between a wake key and the next `scan_tick` the block stays blanked. It wakes only on that tick boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_tick | input | 1 | One-cycle pulse at each scan period boundary |
| strap_off | input | 1 | Feature disable strap |
| wake_rows | input | 11 | Per-row wake enable mask |
| pass_wake | input | 1 | Forward wake keys as normal keys |
| key_valid | input | 1 | Key event valid |
| key_ready | output | 1 | Key event accepted |
| key_row | input | 4 | Key row index |
| key_col | input | 2 | Key column index |
| fwd_valid | output | 1 | Forwarded key valid |
| fwd_ready | input | 1 | Forwarded key taken |
| fwd_row | output | 4 | Forwarded row |
| fwd_col | output | 2 | Forwarded column |
| din_valid | input | 1 | Display slot valid |
| din_ready | output | 1 | Display slot taken |
| din_digit | input | 4 | Digit slot index |
| din_seg | input | 8 | Segment pattern in |
| dout_valid | output | 1 | Driver slot valid |
| dout_ready | input | 1 | Driver slot taken |
| dout_digit | output | 4 | Digit slot index out |
| dout_seg | output | 8 | Segment pattern out |
| blanked | output | 1 | Idle blank state active |

## Verification
The bench sweeps every row and column of a small matrix against the blank state.

- A design that decoded the mask or the dedicated row wrongly would wake on a stray key, stay dark after a valid wake key, or forward a key it should drop.
- An off-by-one in the idle count would blank one tick early or late. A missed counter restart on a dropped key would blank too soon after a non-waking press.
- Every digit index is swept with several segment patterns in both states. This exposes a wrong leftmost index, a minus bar on the wrong bit, or content altered on restore.
- A wake that did not wait for the scan boundary, and a strap that did not clear the blank state at once, are both caught.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  localparam int unsigned SEG_W = 8;
  localparam logic [SEG_W-1:0] SEG_MINUS = 8'h40;
  localparam logic [SEG_W-1:0] SEG_DARK  = 8'h00;
  localparam int unsigned COL_W = 2;

  typedef enum logic {
    ST_LIVE  = 1'b0,
    ST_BLANK = 1'b1
  } blank_state_e;
endpackage

// File: rtl/tmo_idle_timer.sv
module tmo_idle_timer
  import tmo_pkg::*;
#(
  parameter int unsigned TIMEOUT_SCANS = 7273
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_tick,
  input  logic strap_off,
  input  logic key_accept,
  input  logic wake_key,
  output logic blanked
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_SCANS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_SCANS - 1);

  logic [CNT_W-1:0] idle_cnt;
  blank_state_e     state;
  logic             wake_pend;
  logic             expire;

  assign expire  = scan_tick && (state == ST_LIVE) && (idle_cnt == LAST) && !key_accept;
  assign blanked = (state == ST_BLANK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt  <= '0;
      state     <= ST_LIVE;
      wake_pend <= 1'b0;
    end else if (strap_off) begin
      idle_cnt  <= '0;
      state     <= ST_LIVE;
      wake_pend <= 1'b0;
    end else begin
      if (key_accept)
        idle_cnt <= '0;
      else if (scan_tick && state == ST_LIVE && idle_cnt != LAST)
        idle_cnt <= idle_cnt + 1'b1;

      if (state == ST_BLANK) begin
        if (scan_tick && wake_pend) begin
          state     <= ST_LIVE;
          wake_pend <= 1'b0;
        end else begin
          wake_pend <= wake_pend || (key_accept && wake_key);
        end
      end else begin
        wake_pend <= 1'b0;
        if (expire) state <= ST_BLANK;
      end
    end
  end
endmodule

// File: rtl/tmo_wake_qual.sv
module tmo_wake_qual
  import tmo_pkg::*;
#(
  parameter int unsigned NUM_ROWS      = 11,
  parameter int unsigned DEDICATED_ROW = NUM_ROWS - 1
) (
  input  logic [NUM_ROWS-1:0]         wake_rows,
  input  logic [$clog2(NUM_ROWS)-1:0] row,
  input  logic [COL_W-1:0]            col,
  output logic                        is_wake
);
  logic row_hit;
  logic ded_hit;

  always_comb begin
    row_hit = 1'b0;
    for (int i = 0; i < NUM_ROWS; i++)
      if (row == i[$clog2(NUM_ROWS)-1:0] && wake_rows[i]) row_hit = 1'b1;
  end

  assign ded_hit = (row == DEDICATED_ROW[$clog2(NUM_ROWS)-1:0]) && (col < COL_W'(2));
  assign is_wake = row_hit || ded_hit;
endmodule

// File: rtl/tmo_key_fwd.sv
module tmo_key_fwd
  import tmo_pkg::*;
#(
  parameter int unsigned ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_valid,
  output logic             key_ready,
  input  logic [ROW_W-1:0] key_row,
  input  logic [COL_W-1:0] key_col,
  input  logic             keep,
  output logic             key_accept,
  output logic             fwd_valid,
  input  logic             fwd_ready,
  output logic [ROW_W-1:0] fwd_row,
  output logic [COL_W-1:0] fwd_col
);
  assign key_ready  = !fwd_valid || fwd_ready;
  assign key_accept = key_valid && key_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_row   <= '0;
      fwd_col   <= '0;
    end else if (key_accept && keep) begin
      fwd_valid <= 1'b1;
      fwd_row   <= key_row;
      fwd_col   <= key_col;
    end else if (fwd_ready) begin
      fwd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tmo_seg_mask.sv
module tmo_seg_mask
  import tmo_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 9
) (
  input  logic                          blanked,
  input  logic [$clog2(NUM_DIGITS)-1:0] digit,
  input  logic [SEG_W-1:0]              seg_in,
  output logic [SEG_W-1:0]              seg_out
);
  localparam int unsigned DW = $clog2(NUM_DIGITS);
  localparam logic [DW-1:0] LEFT = DW'(NUM_DIGITS - 1);

  always_comb begin
    if (!blanked)             seg_out = seg_in;
    else if (digit == LEFT)   seg_out = SEG_MINUS;
    else                      seg_out = SEG_DARK;
  end
endmodule

// File: rtl/tmo_blanker.sv
module tmo_blanker
  import tmo_pkg::*;
#(
  parameter int unsigned TIMEOUT_SCANS = 7273,
  parameter int unsigned NUM_ROWS      = 11,
  parameter int unsigned NUM_DIGITS    = 9,
  parameter int unsigned DEDICATED_ROW = NUM_ROWS - 1,
  localparam int unsigned ROW_W = $clog2(NUM_ROWS),
  localparam int unsigned DIG_W = $clog2(NUM_DIGITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_tick,
  input  logic                strap_off,
  input  logic [NUM_ROWS-1:0] wake_rows,
  input  logic                pass_wake,
  input  logic                key_valid,
  output logic                key_ready,
  input  logic [ROW_W-1:0]    key_row,
  input  logic [1:0]          key_col,
  output logic                fwd_valid,
  input  logic                fwd_ready,
  output logic [ROW_W-1:0]    fwd_row,
  output logic [1:0]          fwd_col,
  input  logic                din_valid,
  output logic                din_ready,
  input  logic [DIG_W-1:0]    din_digit,
  input  logic [7:0]          din_seg,
  output logic                dout_valid,
  input  logic                dout_ready,
  output logic [DIG_W-1:0]    dout_digit,
  output logic [7:0]          dout_seg,
  output logic                blanked
);
  logic is_wake;
  logic key_accept;
  logic keep;

  tmo_wake_qual #(.NUM_ROWS(NUM_ROWS), .DEDICATED_ROW(DEDICATED_ROW)) u_qual (
    .wake_rows (wake_rows),
    .row       (key_row),
    .col       (key_col),
    .is_wake   (is_wake)
  );

  assign keep = !blanked || (is_wake && pass_wake);

  tmo_key_fwd #(.ROW_W(ROW_W)) u_fwd (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_valid  (key_valid),
    .key_ready  (key_ready),
    .key_row    (key_row),
    .key_col    (key_col),
    .keep       (keep),
    .key_accept (key_accept),
    .fwd_valid  (fwd_valid),
    .fwd_ready  (fwd_ready),
    .fwd_row    (fwd_row),
    .fwd_col    (fwd_col)
  );

  tmo_idle_timer #(.TIMEOUT_SCANS(TIMEOUT_SCANS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_tick  (scan_tick),
    .strap_off  (strap_off),
    .key_accept (key_accept),
    .wake_key   (is_wake),
    .blanked    (blanked)
  );

  tmo_seg_mask #(.NUM_DIGITS(NUM_DIGITS)) u_mask (
    .blanked (blanked),
    .digit   (din_digit),
    .seg_in  (din_seg),
    .seg_out (dout_seg)
  );

  assign dout_valid = din_valid;
  assign din_ready  = dout_ready;
  assign dout_digit = din_digit;
endmodule

// File: rtl/tmo_blanker_chk.sv
module tmo_blanker_chk #(
  parameter int unsigned NUM_DIGITS = 9,
  parameter int unsigned ROW_W = 4,
  parameter int unsigned DIG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scan_tick,
  input logic             strap_off,
  input logic             blanked,
  input logic             fwd_valid,
  input logic             fwd_ready,
  input logic [ROW_W-1:0] fwd_row,
  input logic [1:0]       fwd_col,
  input logic             key_ready,
  input logic             din_valid,
  input logic             dout_valid,
  input logic             din_ready,
  input logic             dout_ready,
  input logic [DIG_W-1:0] din_digit,
  input logic [7:0]       din_seg,
  input logic [7:0]       dout_seg
);
  localparam logic [DIG_W-1:0] LEFT = DIG_W'(NUM_DIGITS - 1);

  assert_enter_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blanked) |-> $past(scan_tick));

  assert_dark_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (blanked && din_digit != LEFT) |-> dout_seg == 8'h00);

  assert_minus_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (blanked && din_digit == LEFT) |-> dout_seg == 8'h40);

  assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !blanked |-> dout_seg == din_seg);

  assert_strap_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strap_off |=> !blanked);

  assert_hold_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_row) && $stable(fwd_col)));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |-> !key_ready);

  assert_stream_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid == din_valid) && (din_ready == dout_ready));

  assert_wake_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blanked) |-> ($past(scan_tick) || $past(strap_off)));
endmodule

bind tmo_blanker tmo_blanker_chk #(
  .NUM_DIGITS(NUM_DIGITS), .ROW_W(ROW_W), .DIG_W(DIG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .strap_off(strap_off),
  .blanked(blanked), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
  .fwd_row(fwd_row), .fwd_col(fwd_col), .key_ready(key_ready),
  .din_valid(din_valid), .dout_valid(dout_valid), .din_ready(din_ready),
  .dout_ready(dout_ready), .din_digit(din_digit), .din_seg(din_seg),
  .dout_seg(dout_seg)
);

// File: tb/tmo_blanker_test.sv
module tmo_blanker_test;
  localparam int T = 5;
  localparam int NR = 11;
  localparam int ND = 9;
  localparam int DED = NR - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_tick = 1'b0, strap_off = 1'b0, pass_wake = 1'b0;
  logic [NR-1:0] wake_rows = 11'h180;
  logic key_valid = 1'b0, key_ready;
  logic [3:0] key_row = '0;
  logic [1:0] key_col = '0;
  logic fwd_valid, fwd_ready = 1'b1;
  logic [3:0] fwd_row;
  logic [1:0] fwd_col;
  logic din_valid = 1'b1, din_ready, dout_valid, dout_ready = 1'b1;
  logic [3:0] din_digit = '0, dout_digit;
  logic [7:0] din_seg = '0, dout_seg;
  logic blanked;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tmo_blanker #(.TIMEOUT_SCANS(T), .NUM_ROWS(NR), .NUM_DIGITS(ND)) uut (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .strap_off(strap_off),
    .wake_rows(wake_rows), .pass_wake(pass_wake),
    .key_valid(key_valid), .key_ready(key_ready), .key_row(key_row), .key_col(key_col),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_row(fwd_row), .fwd_col(fwd_col),
    .din_valid(din_valid), .din_ready(din_ready), .din_digit(din_digit), .din_seg(din_seg),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_digit(dout_digit),
    .dout_seg(dout_seg), .blanked(blanked)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk) scan_tick = 1'b1;
    @(posedge clk);
    @(negedge clk) scan_tick = 1'b0;
  endtask

  task automatic press(input int r, input int c);
    @(negedge clk);
    key_valid = 1'b1; key_row = 4'(r); key_col = 2'(c);
    @(posedge clk);
    @(negedge clk) key_valid = 1'b0;
  endtask

  task automatic go_blank();
    press(0, 0);
    for (int i = 0; i < T; i++) tick();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 blanked", blanked, 0);
    chk("R1 fwd_valid", fwd_valid, 0);
    chk("R1 key_ready", key_ready, 1);

    // R2 entry exactly at the T-th tick
    press(0, 0);
    chk("R9 live key forwarded", fwd_valid, 1);
    for (int i = 0; i < T - 1; i++) tick();
    chk("R2 not yet blanked", blanked, 0);
    tick();
    chk("R2 blanked at T", blanked, 1);
    @(negedge clk) strap_off = 1'b1;
    @(negedge clk) strap_off = 1'b0;

    // R3 restart on key
    press(1, 1);
    for (int i = 0; i < T - 1; i++) tick();
    press(2, 2);
    for (int i = 0; i < T - 1; i++) tick();
    chk("R3 restart kept live", blanked, 0);
    tick();
    chk("R3 blank after restart", blanked, 1);
    // R3 dropped key while blanked restarts count too
    press(0, 2);
    chk("R9 dropped key", fwd_valid, 0);
    press(8, 0);
    tick();
    chk("R6 woke", blanked, 0);
    for (int i = 0; i < T - 1; i++) tick();
    chk("R3 count restarted", blanked, 0);
    tick();
    chk("R3 blank after wake idle", blanked, 1);

    // R4 / R5 display sweep
    for (int d = 0; d < ND; d++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        din_digit = 4'(d);
        din_seg = 8'(8'h5A ^ (p * 8'h33) ^ d);
        #1;
        chk("R4 blanked slot", dout_seg, (d == ND - 1) ? 8'h40 : 8'h00);
        chk("R5 digit index", dout_digit, d);
      end
    end
    press(DED, 0);
    tick();
    chk("R7 dedicated wake", blanked, 0);
    for (int d = 0; d < ND; d++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        din_digit = 4'(d);
        din_seg = 8'(8'h5A ^ (p * 8'h33) ^ d);
        #1;
        chk("R5 restored slot", dout_seg, 8'(8'h5A ^ (p * 8'h33) ^ d));
      end
    end

    // R6 R7 R9 R11 sweep over the matrix
    for (int r = 0; r < NR; r++) begin
      for (int c = 0; c < 3; c++) begin
        bit q;
        q = wake_rows[r] || (r == DED && c < 2);
        pass_wake = (r % 2 == 1);
        go_blank();
        chk("R2 sweep entry", blanked, 1);
        press(r, c);
        chk("R9 forward decision", fwd_valid, (q && pass_wake) ? 1 : 0);
        if (q && pass_wake) begin
          chk("R9 fwd row", fwd_row, r);
          chk("R9 fwd col", fwd_col, c);
        end
        chk("R11 still blanked", blanked, 1);
        tick();
        chk((r == DED) ? "R7 wake decision" : "R6 wake decision", blanked, q ? 0 : 1);
        if (blanked) begin
          @(negedge clk) strap_off = 1'b1;
          @(negedge clk) strap_off = 1'b0;
          chk("R8 strap clears", blanked, 0);
        end
      end
    end

    // R8 strap holds off timeout
    @(negedge clk) strap_off = 1'b1;
    for (int i = 0; i < 3 * T; i++) tick();
    chk("R8 never blanks", blanked, 0);
    strap_off = 1'b0;

    // R10 back-pressure
    @(negedge clk) fwd_ready = 1'b0;
    key_valid = 1'b1; key_row = 4'd3; key_col = 2'd2;
    @(posedge clk);
    @(negedge clk) key_valid = 1'b0;
    chk("R10 held valid", fwd_valid, 1);
    chk("R10 key_ready low", key_ready, 0);
    repeat (2) @(negedge clk);
    chk("R10 held row", fwd_row, 3);
    chk("R10 held col", fwd_col, 2);
    fwd_ready = 1'b1;
    #1;
    chk("R10 ready when draining", key_ready, 1);
    @(negedge clk);
    chk("R10 drained", fwd_valid, 0);
    dout_ready = 1'b0; din_valid = 1'b0;
    #1;
    chk("R10 din_ready follows", din_ready, 0);
    chk("R10 dout_valid follows", dout_valid, 0);
    dout_ready = 1'b1; din_valid = 1'b1;

    finish_run();
  end
endmodule